// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Front End

This block is the bit-level front end of a serial memory target on a two-wire bus with a clock line and an open-drain data line. Both lines are oversampled by a fast system clock through synchronisers. Edges are found by comparing successive samples. A falling data line while the clock line is high marks the opening of a transaction. A rising data line while the clock line is high marks its close.

Between those two conditions the block handles 8-bit words. It shifts words in on clock rising edges and shifts words out after clock falling edges. It pulls the data line low as the acknowledge during the ninth clock of each word it accepts.

The first word of every transaction selects the target. That word must carry a fixed four-bit prefix and three bits equal to the strap inputs. A busy input lets the memory core refuse its address while an internal write is still running, so the bus controller can poll for completion.

The block reports the following to a downstream memory controller as one-cycle pulses:
- opening and closing conditions
- address matches, with the read/write bit
- received data bytes
- the bus controller's acknowledge or refusal after each byte it read

Read data comes from the downstream controller on a byte input. The block samples that input and signals with a pulse each time it takes a byte.

Top module: `tws_target`

## Requirements
- R1: A fall of the data line while the clock line is high gives a one-cycle `start_o` pulse and restarts address reception from bit 0.
- R2: A rise of the data line while the clock line is high gives a one-cycle `stop_o` pulse; the target then releases the data line and ignores the bus until the next opening condition.
- R3: Incoming bits are captured on clock rising edges, most significant bit first; `sda_pull_o` only asserts or changes data bits after a clock falling edge, while the clock line is low.
- R4: The first word after an opening condition is the address: bits 7..4 must be 1010, bits 3..1 must equal `strap_i[2:0]`, and bit 0 is 1 for read and 0 for write. On a match the block pulses `addr_hit_o`, sets `rd_mode_o` to bit 0 and pulls the data line low during the ninth clock.
- R5: On an address mismatch there is no acknowledge and no `addr_hit_o`, and later words give no `rx_valid_o` and no acknowledge until the next opening condition.
- R6: If `busy_i` is high when the eighth address bit is captured, the address is not acknowledged and `addr_hit_o` stays low.
- R7: In write mode each received byte gives one `rx_valid_o` pulse with the byte on `rx_byte_o`, and the data line is pulled low during the ninth clock.
- R8: In read mode, on the clock falling edge that ends an acknowledge, `tx_byte_i` is sampled and `tx_taken_o` pulses. The byte is then sent most significant bit first, where a 0 bit means `sda_pull_o` is high. The line is released during the ninth clock.
- R9: After each sent byte the data line is sampled on the ninth clock rising edge. The block pulses `host_ack_valid_o`, with `host_ack_o` = 1 when the line is low. An acknowledge leads to the next byte being taken. A refusal makes the target release the line and wait for a closing or opening condition.
- R10: An opening condition in the middle of a transfer, with no closing condition before it, discards the partial word and restarts address reception.
- R11: After reset `sda_pull_o` is low and no event output pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| strap_i | input | 3 | Address strap inputs; unconnected straps must be tied low |
| busy_i | input | 1 | High while the memory core cannot accept a transaction |
| tx_byte_i | input | 8 | Next byte to send in read mode |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls the data line low, 0 releases it |
| start_o | output | 1 | Pulse on an opening condition |
| stop_o | output | 1 | Pulse on a closing condition |
| addr_hit_o | output | 1 | Pulse on a matched and accepted address word |
| rd_mode_o | output | 1 | Read/write bit of the last accepted address |
| rx_valid_o | output | 1 | Pulse when a write data byte has been received |
| rx_byte_o | output | 8 | Last received write data byte |
| tx_taken_o | output | 1 | Pulse when `tx_byte_i` has been sampled for sending |
| host_ack_valid_o | output | 1 | Pulse when the controller's response to a read byte is sampled |
| host_ack_o | output | 1 | 1 if that response was an acknowledge (line low) |

## Verification
The address decoder is driven with a table of address words that each break one field: a prefix bit, a strap bit, the read/write bit, or the busy input. The acknowledge bit then shows which field the decoder actually compares. Write bytes with alternating, inverted and all-zero bit patterns separate a shift-order or off-by-one-bit fault from a correct capture. A sequential read that ends on a refusal, and a transaction broken by a repeated opening condition, show whether the next byte is fetched only on acknowledge and whether a half-received word is discarded.

// File: rtl/tws_pkg.sv
package tws_pkg;

  // Bit-engine phases
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,  // ignoring the bus until an opening condition
    ST_ADDR     = 3'd1,  // shifting in the address word
    ST_RECV     = 3'd2,  // shifting in a write data word
    ST_ACK_WAIT = 3'd3,  // word accepted, waiting for clock low to pull
    ST_ACK_HOLD = 3'd4,  // holding acknowledge through the ninth clock
    ST_SEND     = 3'd5,  // shifting out a read data word
    ST_SEND_REL = 3'd6,  // last bit sent, release after the clock falls
    ST_HOST_ACK = 3'd7   // sampling the controller response
  } tws_state_e;

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] sync_o
);

  // One flop chain per bus line; idle bus level is high
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe_q;
    logic [STAGES-1:0] pipe_d;

    always_comb begin
      pipe_d = {pipe_q[STAGES-2:0], raw_i[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '1;
      else        pipe_q <= pipe_d;
    end

    assign sync_o[g] = pipe_q[STAGES-1];
  end

endmodule

// File: rtl/tws_cond.sv
module tws_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    scl_rise = scl_s & ~scl_q;
    scl_fall = ~scl_s & scl_q;
    // data edges only count as conditions with the clock high in both samples
    start_ev = scl_s & scl_q & sda_q & ~sda_s;
    stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
  end

endmodule

// File: rtl/tws_engine.sv
module tws_engine
  import tws_pkg::*;
#(
  parameter int                          WORD_W     = 8,
  parameter int                          STRAP_W    = 3,
  parameter logic [WORD_W-STRAP_W-2:0]   DEV_PREFIX = 4'b1010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_ev,
  input  logic               stop_ev,
  input  logic               sda_s,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               busy_i,
  input  logic [WORD_W-1:0]  tx_byte_i,
  output logic               sda_pull_o,
  output logic               addr_hit_o,
  output logic               rd_mode_o,
  output logic               rx_valid_o,
  output logic [WORD_W-1:0]  rx_byte_o,
  output logic               tx_taken_o,
  output logic               host_ack_valid_o,
  output logic               host_ack_o
);

  localparam int                CNT_W   = $clog2(WORD_W);
  localparam logic [CNT_W-1:0]  LAST    = CNT_W'(WORD_W - 1);

  tws_state_e         state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [WORD_W-1:0]  sh_q, sh_d;
  logic [WORD_W-1:0]  rxb_q, rxb_d;
  logic               rd_q, rd_d;
  logic               pull_q, pull_d;
  logic               hit_q, hit_d;
  logic               rxv_q, rxv_d;
  logic               take_q, take_d;
  logic               hv_q, hv_d;
  logic               ha_q, ha_d;

  logic [WORD_W-1:0]  word_c;
  logic               match_c;

  always_comb begin
    word_c  = {sh_q[WORD_W-2:0], sda_s};
    match_c = (word_c[WORD_W-1:1] == {DEV_PREFIX, strap_i});
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    rxb_d   = rxb_q;
    rd_d    = rd_q;
    pull_d  = pull_q;
    hit_d   = 1'b0;
    rxv_d   = 1'b0;
    take_d  = 1'b0;
    hv_d    = 1'b0;
    ha_d    = ha_q;

    if (stop_ev) begin
      state_d = ST_IDLE;
      pull_d  = 1'b0;
    end else if (start_ev) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      pull_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: if (scl_rise) begin
          sh_d = word_c;
          if (cnt_q == LAST) begin
            cnt_d = '0;
            if (match_c && !busy_i) begin
              hit_d   = 1'b1;
              rd_d    = word_c[0];
              state_d = ST_ACK_WAIT;
            end else begin
              state_d = ST_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_RECV: if (scl_rise) begin
          sh_d = word_c;
          if (cnt_q == LAST) begin
            cnt_d   = '0;
            rxv_d   = 1'b1;
            rxb_d   = word_c;
            state_d = ST_ACK_WAIT;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_ACK_WAIT: if (scl_fall) begin
          pull_d  = 1'b1;
          state_d = ST_ACK_HOLD;
        end
        ST_ACK_HOLD: if (scl_fall) begin
          cnt_d = '0;
          if (rd_q) begin
            sh_d    = tx_byte_i;
            pull_d  = ~tx_byte_i[WORD_W-1];
            take_d  = 1'b1;
            state_d = ST_SEND;
          end else begin
            pull_d  = 1'b0;
            state_d = ST_RECV;
          end
        end
        ST_SEND: begin
          if (scl_rise) begin
            if (cnt_q == LAST) begin
              cnt_d   = '0;
              state_d = ST_SEND_REL;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else if (scl_fall) begin
            sh_d   = {sh_q[WORD_W-2:0], 1'b0};
            pull_d = ~sh_q[WORD_W-2];
          end
        end
        ST_SEND_REL: if (scl_fall) begin
          pull_d  = 1'b0;
          state_d = ST_HOST_ACK;
        end
        ST_HOST_ACK: if (scl_rise) begin
          hv_d    = 1'b1;
          ha_d    = ~sda_s;
          state_d = sda_s ? ST_IDLE : ST_ACK_HOLD;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      rxb_q   <= '0;
      rd_q    <= 1'b0;
      pull_q  <= 1'b0;
      hit_q   <= 1'b0;
      rxv_q   <= 1'b0;
      take_q  <= 1'b0;
      hv_q    <= 1'b0;
      ha_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      rxb_q   <= rxb_d;
      rd_q    <= rd_d;
      pull_q  <= pull_d;
      hit_q   <= hit_d;
      rxv_q   <= rxv_d;
      take_q  <= take_d;
      hv_q    <= hv_d;
      ha_q    <= ha_d;
    end
  end

  assign sda_pull_o       = pull_q;
  assign addr_hit_o       = hit_q;
  assign rd_mode_o        = rd_q;
  assign rx_valid_o       = rxv_q;
  assign rx_byte_o        = rxb_q;
  assign tx_taken_o       = take_q;
  assign host_ack_valid_o = hv_q;
  assign host_ack_o       = ha_q;

  // R6
  busy_blocks_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit_o |-> !$past(busy_i));

  // R2
  stop_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (!sda_pull_o && state_q == ST_IDLE));

  // R10
  start_discards_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && !stop_ev) |=> (!sda_pull_o && !rx_valid_o && state_q == ST_ADDR));

  // R9
  host_ack_line_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack_valid_o |-> !sda_pull_o);

  // R8
  taken_only_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_taken_o |-> rd_mode_o);

endmodule

// File: rtl/tws_target.sv
module tws_target #(
  parameter int                         WORD_W      = 8,
  parameter int                         STRAP_W     = 3,
  parameter int                         SYNC_STAGES = 2,
  parameter logic [WORD_W-STRAP_W-2:0]  DEV_PREFIX  = 4'b1010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               busy_i,
  input  logic [WORD_W-1:0]  tx_byte_i,
  output logic               sda_pull_o,
  output logic               start_o,
  output logic               stop_o,
  output logic               addr_hit_o,
  output logic               rd_mode_o,
  output logic               rx_valid_o,
  output logic [WORD_W-1:0]  rx_byte_o,
  output logic               tx_taken_o,
  output logic               host_ack_valid_o,
  output logic               host_ack_o
);

  localparam int LINES = 2;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [LINES-1:0] lines_s;
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  tws_sync #(.STAGES(SYNC_STAGES), .LINES(LINES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .raw_i  ({sda_i, scl_i}),
    .sync_o (lines_s)
  );
  assign scl_s = lines_s[0];
  assign sda_s = lines_s[1];

  tws_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  tws_engine #(.WORD_W(WORD_W), .STRAP_W(STRAP_W), .DEV_PREFIX(DEV_PREFIX)) u_engine (
    .clk              (clk),
    .rst_n            (rst_int_n),
    .scl_rise         (scl_rise),
    .scl_fall         (scl_fall),
    .start_ev         (start_ev),
    .stop_ev          (stop_ev),
    .sda_s            (sda_s),
    .strap_i          (strap_i),
    .busy_i           (busy_i),
    .tx_byte_i        (tx_byte_i),
    .sda_pull_o       (sda_pull_o),
    .addr_hit_o       (addr_hit_o),
    .rd_mode_o        (rd_mode_o),
    .rx_valid_o       (rx_valid_o),
    .rx_byte_o        (rx_byte_o),
    .tx_taken_o       (tx_taken_o),
    .host_ack_valid_o (host_ack_valid_o),
    .host_ack_o       (host_ack_o)
  );

  logic start_q, stop_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      start_q <= start_ev;
      stop_q  <= stop_ev;
    end
  end
  assign start_o = start_q;
  assign stop_o  = stop_q;

  // R3
  pull_rise_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(sda_pull_o) |-> !$past(scl_s));

  // R3
  pull_fall_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(sda_pull_o) |-> (!$past(scl_s) || $past(start_ev) || $past(stop_ev)));

  // R1
  events_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({start_o, stop_o, addr_hit_o, rx_valid_o, host_ack_valid_o}));

endmodule

// File: tb/tb_tws_target.sv
module tb_tws_target;

  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_host = 1'b1;
  logic [2:0] strap = 3'd0;
  logic       busy = 1'b0;
  logic [7:0] tx_byte = 8'hA5;
  logic       sda_line;

  logic       sda_pull, start_p, stop_p, hit_p, rd_mode, rxv_p, take_p, hv_p, hack;
  logic [7:0] rx_byte;

  always #10 clk = ~clk;   // 50 MHz

  assign sda_line = sda_host & ~sda_pull;

  tws_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap_i(strap), .busy_i(busy), .tx_byte_i(tx_byte),
    .sda_pull_o(sda_pull), .start_o(start_p), .stop_o(stop_p),
    .addr_hit_o(hit_p), .rd_mode_o(rd_mode), .rx_valid_o(rxv_p),
    .rx_byte_o(rx_byte), .tx_taken_o(take_p),
    .host_ack_valid_o(hv_p), .host_ack_o(hack)
  );

  int nchk = 0, nfail = 0;
  int n_start = 0, n_stop = 0, n_hit = 0, n_rx = 0, n_take = 0, n_hv = 0;
  logic [7:0] last_rx = 8'h00;
  logic       last_hack = 1'b0;

  // event monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (start_p) n_start++;
      if (stop_p)  n_stop++;
      if (hit_p)   n_hit++;
      if (rxv_p) begin n_rx++; last_rx = rx_byte; end
      if (hv_p)  begin n_hv++; last_hack = hack; end
      if (take_p) begin n_take++; tx_byte = tx_byte + 8'h11; end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_host = 1'b1; wq(Q); scl = 1'b1; wq(Q);
    sda_host = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    sda_host = 1'b0; wq(Q); scl = 1'b1; wq(Q);
    sda_host = 1'b1; wq(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_host = b; wq(Q); scl = 1'b1; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic ack_bit(output logic acked);
    sda_host = 1'b1; wq(Q); scl = 1'b1; wq(Q/2);
    acked = ~sda_line; wq(Q/2); scl = 1'b0; wq(Q);
  endtask

  task automatic read_byte(output logic [7:0] b);
    sda_host = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wq(Q); scl = 1'b1; wq(Q/2);
      b = {b[6:0], sda_line};
      wq(Q/2); scl = 1'b0;
    end
    wq(Q);
  endtask

  task automatic host_resp(input logic give_ack);
    sda_host = ~give_ack; wq(Q); scl = 1'b1; wq(Q); scl = 1'b0; wq(Q);
    sda_host = 1'b1; wq(Q);
  endtask

  // address table: {addr[12:5], strap[4:2], busy[1], exp_ack[0]}
  localparam logic [12:0] VEC [9] = '{
    {8'hA0, 3'd0, 1'b0, 1'b1},
    {8'hAE, 3'd7, 1'b0, 1'b1},
    {8'hA6, 3'd3, 1'b0, 1'b1},
    {8'hA5, 3'd2, 1'b0, 1'b1},
    {8'hA8, 3'd3, 1'b0, 1'b0},
    {8'hB0, 3'd0, 1'b0, 1'b0},
    {8'hE0, 3'd0, 1'b0, 1'b0},
    {8'hA4, 3'd3, 1'b0, 1'b0},
    {8'hA0, 3'd0, 1'b1, 1'b0}
  };

  initial begin
    logic       got;
    logic [7:0] b;
    logic [7:0] base;
    int h0, r0, s0, p0, t0, v0;

    wq(5); rst_n = 1'b1; wq(5);
    // R11 reset state
    check("R11 pull after reset", sda_pull, 0);
    check("R11 no events after reset", n_start + n_stop + n_hit + n_rx + n_take + n_hv, 0);

    // address decode table (R4 match, R5 mismatch, R6 busy)
    for (int k = 0; k < 9; k++) begin
      logic [12:0] v;
      string tag;
      v = VEC[k];
      tag = v[0] ? "R4" : (v[1] ? "R6" : "R5");
      strap = v[4:2]; busy = v[1];
      h0 = n_hit;
      bus_start;
      send_byte(v[12:5]);
      ack_bit(got);
      check({tag, " address ack"}, got, v[0]);
      check({tag, " addr_hit count"}, n_hit - h0, v[0] ? 1 : 0);
      if (v[0]) check("R4 read/write bit", rd_mode, v[5]);
      if (got && v[5]) begin
        read_byte(b);
        host_resp(1'b0);
      end
      busy = 1'b0;
      bus_stop;
    end

    // R7 write bytes, R1/R2 condition pulses
    strap = 3'd0;
    s0 = n_start; p0 = n_stop; r0 = n_rx;
    bus_start;
    check("R1 start pulse", n_start - s0, 1);
    send_byte(8'hA0); ack_bit(got);
    check("R4 write address ack", got, 1);
    send_byte(8'h3C); ack_bit(got);
    check("R7 ack byte 0x3C", got, 1);
    check("R7 rx byte 0x3C", last_rx, 8'h3C);
    send_byte(8'hC3); ack_bit(got);
    check("R7 rx byte 0xC3", last_rx, 8'hC3);
    send_byte(8'h00); ack_bit(got);
    check("R7 ack byte 0x00", got, 1);
    check("R7 rx byte 0x00", last_rx, 8'h00);
    check("R7 rx count", n_rx - r0, 3);
    bus_stop;
    check("R2 stop pulse", n_stop - p0, 1);
    check("R2 line released", sda_pull, 0);

    // R5 mismatch: following bytes ignored
    r0 = n_rx;
    bus_start;
    send_byte(8'hA2); ack_bit(got);
    check("R5 mismatch no ack", got, 0);
    send_byte(8'h55); ack_bit(got);
    check("R5 later byte no ack", got, 0);
    check("R5 later byte no rx", n_rx - r0, 0);
    bus_stop;

    // R8/R9 sequential read
    base = tx_byte; t0 = n_take; v0 = n_hv;
    bus_start;
    send_byte(8'hA1); ack_bit(got);
    check("R4 read address ack", got, 1);
    read_byte(b);
    check("R8 first read byte", b, base);
    check("R8 tx_taken once", n_take - t0, 1);
    host_resp(1'b1);
    check("R9 controller ack seen", last_hack, 1);
    read_byte(b);
    check("R8 second read byte", b, base + 8'h11);
    host_resp(1'b0);
    check("R9 controller nack seen", last_hack, 0);
    check("R9 response count", n_hv - v0, 2);
    check("R9 no fetch after nack", n_take - t0, 2);
    check("R9 line released after nack", sda_pull, 0);
    bus_stop;

    // R10 repeated start mid-transfer
    s0 = n_start; p0 = n_stop; r0 = n_rx;
    bus_start;
    send_byte(8'hA0); ack_bit(got);
    send_byte(8'h5A); ack_bit(got);
    check("R10 byte before restart", last_rx, 8'h5A);
    bus_start;
    send_byte(8'hA1); ack_bit(got);
    check("R10 address after restart ack", got, 1);
    check("R10 read mode after restart", rd_mode, 1);
    check("R10 no stop in between", n_stop - p0, 0);
    check("R10 two start pulses", n_start - s0, 2);
    check("R10 partial word dropped", n_rx - r0, 1);
    read_byte(b);
    host_resp(1'b0);
    bus_stop;

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule